// File: doc/BRIEF.md
# PCI Legacy Interrupt Routing Matrix

This block steers the level-sensitive, active-low legacy interrupt lines of up to 32 internal PCI functions onto a small set of shared interrupt lines. From there it can also steer them onto the IRQ inputs of a legacy interrupt controller. Every function has four lines (A to D). A per-function routing register picks, for each of the four lines on its own, one of eight shared lines. A shared line is low whenever any line mapped to it is low.

The eight shared lines always go out to the advanced interrupt controller. Each shared line also has a control register. That register can connect the line to one of eleven permitted legacy IRQ numbers, or keep it off the legacy side. The path from the interrupt inputs to both output groups is purely combinational. Configuration goes through a plain single-cycle write/read port. There is no flow control on that port: a write strobe is always accepted in the cycle it is seen. All interrupt pins are plain levels with no handshake, so the block never exerts back-pressure.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset, the routing register of every function reads 0x688 (line A to shared line 0, B to 1, C to 2, D to 3). Every shared-line control register reads 0x080, which means kept off the legacy side.
- R2: Addresses 0..NUM_DEV-1 hold the function routing registers. Bits [2:0] select line A's target, [5:3] line B's, [8:6] line C's and [11:9] line D's. A write sets all 12 bits and shows in read data and in routing from the first cycle after the accepting clock edge, not before.
- R3: Each of a function's four lines is routed on its own to any of the eight shared lines, as its 3-bit field selects.
- R4: shared_n[k] is low in the same cycle exactly when at least one function line whose field selects k is low (wired-OR of all contributors).
- R5: shared_n reflects the function lines whatever the legacy control registers contain.
- R6: Addresses NUM_DEV..NUM_DEV+7 hold the control registers of shared lines 0..7. Bits [3:0] hold an IRQ number and bit 7 holds a detach flag; other bits read 0. With bit 7 = 0 and a permitted number, legacy_n[number] goes low while that shared line is low.
- R7: With bit 7 = 1, the shared line has no effect on any legacy_n output.
- R8: The permitted IRQ numbers are 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15. Any other number drives no legacy output, and legacy_n bits 0, 1, 2, 8 and 13 stay high.
- R9: A legacy_n output is low when any attached shared line that selects it is low.
- R10: Writes to addresses at or above NUM_DEV+8 change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe, accepted at the clock edge where it is high |
| cfg_addr | input | 6 | Register address for reads and writes |
| cfg_wdata | input | 12 | Write data |
| cfg_rdata | output | 12 | Read data of the register at cfg_addr, combinational |
| dev_int_n | input | 128 | Function interrupt lines, active low; bit 4*f+l is line l (A=0..D=3) of function f |
| shared_n | output | 8 | Shared interrupt lines to the advanced controller, active low |
| legacy_n | output | 16 | Legacy controller IRQ inputs, active low, bit n is IRQ n |

## Verification
A corrupted routing field shows in the same cycle as a low line appearing on the wrong shared output, or missing from the right one. The bench drives every function line alone under several full register patterns, so each wrong field is caught on the first probe of that line. A corrupted legacy control register or permitted-number mask shows at once as a wrong or extra low legacy output: the bench tries every number on every shared line, both attached and detached. A write that lands early, late or at the wrong address shows in the read data of the next cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int LINES_PER_DEV = 4;
  localparam int SHARED_NUM    = 8;
  localparam int SHARED_IW     = $clog2(SHARED_NUM);
  localparam int ROUTE_W       = LINES_PER_DEV * SHARED_IW;
  localparam int LEG_NUM       = 16;
  localparam int LEG_CW        = $clog2(LEG_NUM);
  // permitted legacy IRQ numbers: 3-7, 9-12, 14, 15
  localparam logic [LEG_NUM-1:0] LEG_PERMIT = 16'hDEF8;
  localparam int DETACH_BIT    = 7;
endpackage

// File: rtl/irq_dev_route_regs.sv
module irq_dev_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_DEV = 32,
  localparam int DEV_IW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [DEV_IW-1:0]                idx,
  input  logic [ROUTE_W-1:0]               wr_data,
  output logic [ROUTE_W-1:0]               rd_data,
  output logic [NUM_DEV*ROUTE_W-1:0]       route_flat
);
  logic [ROUTE_W-1:0] regs [NUM_DEV];
  logic [ROUTE_W-1:0] reset_val;

  always_comb begin
    for (int l = 0; l < LINES_PER_DEV; l++)
      reset_val[l*SHARED_IW +: SHARED_IW] = SHARED_IW'(l);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DEV; d++) regs[d] <= reset_val;
    end else if (wr_en) begin
      regs[idx] <= wr_data;
    end
  end

  assign rd_data = regs[idx];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_flat
    assign route_flat[d*ROUTE_W +: ROUTE_W] = regs[d];
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(idx)] == $past(wr_data));
endmodule

// File: rtl/irq_shared_fanin.sv
module irq_shared_fanin
  import irq_route_pkg::*;
#(
  parameter int NUM_DEV = 32,
  localparam int LINES = NUM_DEV * LINES_PER_DEV
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LINES-1:0]            dev_int_n,
  input  logic [NUM_DEV*ROUTE_W-1:0]  route_flat,
  output logic [SHARED_NUM-1:0]       shared_n
);
  logic [SHARED_NUM-1:0] active;

  always_comb begin
    active = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!dev_int_n[i])
        active[route_flat[i*SHARED_IW +: SHARED_IW]] = 1'b1;
    end
  end

  assign shared_n = ~active;

  p_idle_inputs_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&dev_int_n) |-> (&shared_n));

  p_any_low_reaches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&dev_int_n) |-> !(&shared_n));
endmodule

// File: rtl/irq_legacy_steer.sv
module irq_legacy_steer
  import irq_route_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SHARED_IW-1:0]  idx,
  input  logic                  wr_detach,
  input  logic [LEG_CW-1:0]     wr_code,
  output logic                  rd_detach,
  output logic [LEG_CW-1:0]     rd_code,
  input  logic [SHARED_NUM-1:0] shared_n,
  output logic [LEG_NUM-1:0]    legacy_n
);
  logic [SHARED_NUM-1:0] detach;
  logic [LEG_CW-1:0]     code [SHARED_NUM];
  logic [LEG_NUM-1:0]    drive;
  logic [SHARED_NUM-1:0] feeding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      detach <= '1;
      for (int k = 0; k < SHARED_NUM; k++) code[k] <= '0;
    end else if (wr_en) begin
      detach[idx] <= wr_detach;
      code[idx]   <= wr_code;
    end
  end

  assign rd_detach = detach[idx];
  assign rd_code   = code[idx];

  always_comb begin
    drive = '0;
    for (int k = 0; k < SHARED_NUM; k++) begin
      if (!shared_n[k] && !detach[k] && LEG_PERMIT[code[k]])
        drive[code[k]] = 1'b1;
    end
  end

  assign legacy_n = ~drive;
  assign feeding  = ~shared_n & ~detach;

  p_forbidden_irq_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    &(legacy_n | LEG_PERMIT));

  p_detached_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (feeding == '0) |-> (&legacy_n));

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (code[$past(idx)] == $past(wr_code)) && (detach[$past(idx)] == $past(wr_detach)));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int NUM_DEV = 32,
  parameter int ADDR_W  = 6,
  localparam int DEV_IW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int LINES  = NUM_DEV * LINES_PER_DEV
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [ROUTE_W-1:0]  cfg_wdata,
  output logic [ROUTE_W-1:0]  cfg_rdata,
  input  logic [LINES-1:0]    dev_int_n,
  output logic [SHARED_NUM-1:0] shared_n,
  output logic [LEG_NUM-1:0]  legacy_n
);
  localparam logic [ADDR_W-1:0] DEV_END = ADDR_W'(NUM_DEV);
  localparam logic [ADDR_W-1:0] CTL_END = ADDR_W'(NUM_DEV + SHARED_NUM);

  logic                       dev_hit, ctl_hit;
  logic [DEV_IW-1:0]          dev_idx;
  logic [SHARED_IW-1:0]       ctl_idx;
  logic [ROUTE_W-1:0]         dev_rd;
  logic                       ctl_rd_detach;
  logic [LEG_CW-1:0]          ctl_rd_code;
  logic [NUM_DEV*ROUTE_W-1:0] route_flat;

  assign dev_hit = cfg_addr < DEV_END;
  assign ctl_hit = (cfg_addr >= DEV_END) && (cfg_addr < CTL_END);
  assign dev_idx = DEV_IW'(cfg_addr);
  assign ctl_idx = SHARED_IW'(cfg_addr - DEV_END);

  irq_dev_route_regs #(.NUM_DEV(NUM_DEV)) u_dev_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we && dev_hit),
    .idx        (dev_idx),
    .wr_data    (cfg_wdata),
    .rd_data    (dev_rd),
    .route_flat (route_flat)
  );

  irq_shared_fanin #(.NUM_DEV(NUM_DEV)) u_fanin (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_int_n  (dev_int_n),
    .route_flat (route_flat),
    .shared_n   (shared_n)
  );

  irq_legacy_steer u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we && ctl_hit),
    .idx       (ctl_idx),
    .wr_detach (cfg_wdata[DETACH_BIT]),
    .wr_code   (cfg_wdata[LEG_CW-1:0]),
    .rd_detach (ctl_rd_detach),
    .rd_code   (ctl_rd_code),
    .shared_n  (shared_n),
    .legacy_n  (legacy_n)
  );

  always_comb begin
    cfg_rdata = '0;
    if (dev_hit) begin
      cfg_rdata = dev_rd;
    end else if (ctl_hit) begin
      cfg_rdata[DETACH_BIT] = ctl_rd_detach;
      cfg_rdata[LEG_CW-1:0] = ctl_rd_code;
    end
  end

  p_unmapped_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr >= CTL_END) |-> (cfg_rdata == '0));
endmodule

// File: tb/irq_route_matrix_bench.sv
module irq_route_matrix_bench;
  localparam int ND = 32;
  localparam int NL = ND * 4;
  localparam logic [15:0] PERMIT = 16'hDEF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [11:0] cfg_rdata;
  logic [NL-1:0] dev_int_n = '1;
  logic [7:0]  shared_n;
  logic [15:0] legacy_n;

  logic [11:0] dev_m [ND];
  logic [11:0] ctl_m [8];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route_matrix u_irq_route_matrix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_int_n(dev_int_n),
    .shared_n(shared_n), .legacy_n(legacy_n)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_shared();
    logic [7:0] a = '0;
    for (int d = 0; d < ND; d++)
      for (int l = 0; l < 4; l++)
        if (!dev_int_n[d*4+l]) a[(dev_m[d] >> (3*l)) & 12'h7] = 1'b1;
    return ~a;
  endfunction

  function automatic logic [15:0] exp_legacy();
    logic [7:0]  s = exp_shared();
    logic [15:0] h = '0;
    for (int k = 0; k < 8; k++)
      if (!s[k] && !ctl_m[k][7] && PERMIT[ctl_m[k][3:0]]) h[ctl_m[k][3:0]] = 1'b1;
    return ~h;
  endfunction

  task automatic chk_out(string req);
    chk({req, " shared"}, {8'h00, shared_n}, {8'h00, exp_shared()});
    chk({req, " legacy"}, legacy_n, exp_legacy());
  endtask

  task automatic wr(int a, logic [11:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = v;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (a < ND) dev_m[a] = v;
    else if (a < ND + 8) ctl_m[a-ND] = v & 12'h08F;
  endtask

  task automatic rd_chk(string req, int a);
    logic [11:0] e;
    @(negedge clk);
    cfg_addr = 6'(a);
    #1;
    e = (a < ND) ? dev_m[a] : (a < ND + 8) ? ctl_m[a-ND] : 12'h000;
    chk(req, {4'h0, cfg_rdata}, {4'h0, e});
  endtask

  task automatic drive(string req, logic [NL-1:0] v);
    @(negedge clk);
    dev_int_n = v;
    #1;
    chk_out(req);
  endtask

  function automatic logic [NL-1:0] one_low(int i);
    logic [NL-1:0] v = '1;
    v[i] = 1'b0;
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < ND; d++) dev_m[d] = 12'h688;
    for (int k = 0; k < 8; k++) ctl_m[k] = 12'h080;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset contents and quiet outputs
    for (int a = 0; a < ND + 8; a++) rd_chk("R1 reset value", a);
    drive("R1 idle outputs", '1);

    // R1/R3: reset routing, each line alone
    for (int i = 0; i < 8; i++) drive("R1 reset routing", one_low(i));

    // R10: unmapped writes ignored, reads zero
    for (int a = ND + 8; a < 64; a++) wr(a, 12'hFFF);
    for (int a = ND + 8; a < 64; a++) rd_chk("R10 unmapped read", a);
    rd_chk("R10 dev reg untouched", 0);
    rd_chk("R10 ctl reg untouched", ND);
    drive("R10 routing untouched", one_low(1));
    drive("R10 idle", '1);

    // R2 timing: write invisible before edge, visible after
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'd5; cfg_wdata = 12'h123;
    #1;
    chk("R2 not before edge", {4'h0, cfg_rdata}, 16'h0688);
    @(posedge clk); #1; cfg_we = 1'b0; dev_m[5] = 12'h123;
    rd_chk("R2 after edge", 5);

    // R2/R3/R4/R5: full patterns, each line alone
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < ND; d++) begin
        logic [11:0] v = '0;
        for (int l = 0; l < 4; l++) v[3*l +: 3] = 3'((d*3 + l*5 + p) % 8);
        wr(d, v);
      end
      if (p == 2)
        for (int k = 0; k < 8; k++) wr(ND + k, 12'((k * 5 + 3) % 16));
      for (int d = 0; d < ND; d++) rd_chk("R2 readback", d);
      for (int i = 0; i < NL; i++)
        drive((p == 2) ? "R5 shared with legacy attached" : "R3 single line", one_low(i));
    end

    // R4: many lines at once
    for (int n = 0; n < 60; n++) begin
      logic [NL-1:0] v;
      for (int w = 0; w < NL / 32; w++) v[w*32 +: 32] = $urandom | $urandom | $urandom;
      drive("R4 wired-OR", v);
    end
    drive("R4 idle", '1);
    for (int k = 0; k < 8; k++) wr(ND + k, 12'h080);

    // R6/R7/R8: every number on every shared line
    for (int k = 0; k < 8; k++) begin
      wr(0, {dev_m[0][11:3], 3'(k)});
      for (int c = 0; c < 16; c++) begin
        wr(ND + k, 12'(c));
        rd_chk("R6 ctl readback", ND + k);
        drive(PERMIT[c] ? "R6 attached" : "R8 forbidden number", one_low(0));
        wr(ND + k, 12'h080 | 12'(c));
        drive("R7 detached", one_low(0));
        drive("R7 idle", '1);
      end
      wr(ND + k, 12'h080);
    end

    // R9: two shared lines on one IRQ
    wr(0, {dev_m[0][11:3], 3'd2});
    wr(1, {dev_m[1][11:3], 3'd5});
    wr(ND + 2, 12'd10);
    wr(ND + 5, 12'd10);
    drive("R9 both", one_low(0) & one_low(4));
    drive("R9 first", one_low(0));
    drive("R9 second", one_low(4));
    drive("R9 none", '1);
    chk("R9 none explicit", legacy_n, 16'hFFFF);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule